// File: doc/BRIEF.md
# PCI Express Receive Status Resolver

This block sits on the MAC side of a PHY interface for PCI Express. Each clock it gathers the receive-path event flags raised in that cycle, together with an optional 3-bit status code from the PHY, and folds them into one registered 3-bit status by a fixed priority. The two codes a PHY may use for skip insertion and removal carry no meaning here. They are treated as ordinary received data. The block also keeps the most recent error status in a register.

Skip insertion and removal are instead found by watching the received symbol stream. The block counts the skip symbols in each skip ordered set and reports the count with a one-cycle strobe. It raises a flag when the count is above or below the standard three. The symbol input is a valid/ready stream, but the block never applies back-pressure: `sym_ready` is held high, and a symbol is taken on every cycle where `sym_valid` is high. Status and event pins are plain control signals with no handshake.

Top module: `rxst_resolver`

## Requirements
- R1: `rx_status` is registered and shows the resolved status of the inputs one clock after they are presented. A synchronous reset (`rst` high) drives it to 000. Codes: 000 received data, 011 receiver detected, 100 decode error, 101 elastic buffer overflow, 110 elastic buffer underflow, 111 disparity error.
- R2: The `ev_flags` bits are bit0 receiver detected, bit1 decode error, bit2 overflow, bit3 underflow and bit4 disparity error. When several are active at once, the lowest-numbered active bit wins, so the priority runs from receiver detected (highest) down to disparity error. With no flag active the status is 000.
- R3: When `phy_status_valid` is high, a `phy_status` of 011/100/101/110/111 counts as the matching event and competes under R2. A `phy_status` of 000, 001 or 010, or any code while `phy_status_valid` is low, contributes nothing.
- R4: `rx_status` never takes the value 001 or 010.
- R5: `last_err` updates in the same cycle as `rx_status` to any non-000 status, holds its value while the status is 000, and resets to 000.
- R6: A skip ordered set begins with an accepted COM symbol (`sym_data`=8'hBC, `sym_is_k`=1). It continues with SKP symbols (8'h1C, `sym_is_k`=1) and ends at the first accepted symbol that is not SKP. One clock after that ending symbol, `skip_cnt_valid` is high for one cycle and `skip_cnt` carries the number of SKP symbols. Cycles with `sym_valid` low change nothing.
- R7: With the strobe, `skip_added` is high if the count exceeds 3 and `skip_removed` is high if the count is below 3. With a count of exactly 3, neither is high. Both flags are low whenever the strobe is low.
- R8: A COM followed directly by a non-SKP symbol produces no report. A COM that ends a set also starts a new set.
- R9: The count saturates at 2^CNT_W-1 (15 by default).
- R10: `sym_ready` is always 1, so every symbol presented with `sym_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_flags | input | 5 | Event flags for this cycle, bit positions as in R2 |
| phy_status_valid | input | 1 | Qualifies phy_status |
| phy_status | input | 3 | Status code from the PHY |
| sym_valid | input | 1 | Received symbol present |
| sym_ready | output | 1 | Always high; no back-pressure |
| sym_data | input | 8 | Received symbol byte |
| sym_is_k | input | 1 | Symbol is a control character |
| rx_status | output | 3 | Resolved status, registered |
| last_err | output | 3 | Most recent non-000 status |
| skip_cnt_valid | output | 1 | One-cycle strobe for a finished skip set |
| skip_cnt | output | 4 | SKP count of the finished set |
| skip_added | output | 1 | Count above the standard three |
| skip_removed | output | 1 | Count below the standard three |

## Verification
A wrong priority or normalisation shows on `rx_status` exactly one clock after the offending flag pattern, so all 32 flag combinations are crossed with every PHY code and each result is compared in its own cycle. A wrong internal state in the skip tracker stays hidden until the set ends. It then shows one clock after the terminating symbol, as a missing or extra strobe, a wrong count or a wrong flag. For that reason the set lengths 1, 2, 3, 4 and 17, back-to-back sets, sets broken up by idle cycles and COM-only sequences are all driven. A stale `last_err` appears in the first cycle where the status returns to 000.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
  localparam int NUM_EV = 5;
  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    ST_DATA   = 3'b000,
    ST_SKADD  = 3'b001,
    ST_SKREM  = 3'b010,
    ST_RXDET  = 3'b011,
    ST_DECERR = 3'b100,
    ST_OVF    = 3'b101,
    ST_UNF    = 3'b110,
    ST_DISP   = 3'b111
  } rx_status_e;

  localparam logic [2:0] EV_BASE = ST_RXDET;
endpackage

// File: rtl/rxst_phy_norm.sv
module rxst_phy_norm
  import rxst_pkg::*;
(
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic [NUM_EV-1:0] ev_out
);
  always_comb begin
    ev_out = '0;
    if (code_valid) begin
      unique case (rx_status_e'(code_in))
        ST_RXDET:  ev_out[0] = 1'b1;
        ST_DECERR: ev_out[1] = 1'b1;
        ST_OVF:    ev_out[2] = 1'b1;
        ST_UNF:    ev_out[3] = 1'b1;
        ST_DISP:   ev_out[4] = 1'b1;
        default:   ev_out = '0;  // data, skip add, skip remove: no event
      endcase
    end
  end
endmodule

// File: rtl/rxst_prio.sv
module rxst_prio
  import rxst_pkg::*;
(
  input  logic [NUM_EV-1:0] flags,
  output logic [CODE_W-1:0] code
);
  // Lowest index wins; scan from the bottom priority upward.
  always_comb begin
    code = ST_DATA;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (flags[i]) code = EV_BASE + CODE_W'(i);
    end
  end
endmodule

// File: rtl/rxst_skip_track.sv
module rxst_skip_track #(
  parameter int          CNT_W     = 4,
  parameter int          STD_SKIPS = 3,
  parameter logic [7:0]  COM_SYM   = 8'hBC,
  parameter logic [7:0]  SKP_SYM   = 8'h1C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [7:0]       sym_data,
  input  logic             sym_is_k,
  output logic             rep_valid,
  output logic [CNT_W-1:0] rep_cnt,
  output logic             rep_added,
  output logic             rep_removed
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_STD = CNT_W'(STD_SKIPS);

  typedef enum logic {SK_IDLE, SK_IN_SET} sk_state_e;

  sk_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             is_com, is_skp;

  assign is_com = sym_is_k && (sym_data == COM_SYM);
  assign is_skp = sym_is_k && (sym_data == SKP_SYM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SK_IDLE;
      cnt         <= '0;
      rep_valid   <= 1'b0;
      rep_cnt     <= '0;
      rep_added   <= 1'b0;
      rep_removed <= 1'b0;
    end else begin
      rep_valid   <= 1'b0;
      rep_added   <= 1'b0;
      rep_removed <= 1'b0;
      if (sym_valid) begin
        unique case (state)
          SK_IDLE: begin
            if (is_com) begin
              state <= SK_IN_SET;
              cnt   <= '0;
            end
          end
          SK_IN_SET: begin
            if (is_skp) begin
              if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else begin
              if (cnt != '0) begin
                rep_valid   <= 1'b1;
                rep_cnt     <= cnt;
                rep_added   <= (cnt > CNT_STD);
                rep_removed <= (cnt < CNT_STD);
              end
              cnt   <= '0;
              state <= is_com ? SK_IN_SET : SK_IDLE;
            end
          end
          default: state <= SK_IDLE;
        endcase
      end
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rep_added && rep_removed)); // R7
  AST_FLAG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rep_added || rep_removed) |-> rep_valid); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> !rep_valid); // R6
  AST_NO_EMPTY_REPORT: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> (rep_cnt != '0)); // R8
  AST_IDLE_SYMBOL_INERT: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> !rep_valid); // R6
endmodule

// File: rtl/rxst_resolver.sv
module rxst_resolver
  import rxst_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int STD_SKIPS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       ev_flags,
  input  logic             phy_status_valid,
  input  logic [2:0]       phy_status,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [7:0]       sym_data,
  input  logic             sym_is_k,
  output logic [2:0]       rx_status,
  output logic [2:0]       last_err,
  output logic             skip_cnt_valid,
  output logic [CNT_W-1:0] skip_cnt,
  output logic             skip_added,
  output logic             skip_removed
);
  logic [NUM_EV-1:0] phy_ev, all_ev;
  logic [CODE_W-1:0] resolved;

  assign sym_ready = 1'b1;

  rxst_phy_norm u_norm (
    .code_valid (phy_status_valid),
    .code_in    (phy_status),
    .ev_out     (phy_ev)
  );

  assign all_ev = ev_flags | phy_ev;

  rxst_prio u_prio (
    .flags (all_ev),
    .code  (resolved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_status <= ST_DATA;
      last_err  <= ST_DATA;
    end else begin
      rx_status <= resolved;
      if (resolved != ST_DATA) last_err <= resolved;
    end
  end

  rxst_skip_track #(
    .CNT_W     (CNT_W),
    .STD_SKIPS (STD_SKIPS)
  ) u_skip (
    .clk         (clk),
    .rst         (rst),
    .sym_valid   (sym_valid),
    .sym_data    (sym_data),
    .sym_is_k    (sym_is_k),
    .rep_valid   (skip_cnt_valid),
    .rep_cnt     (skip_cnt),
    .rep_added   (skip_added),
    .rep_removed (skip_removed)
  );

  AST_RXDET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_flags[0] |=> (rx_status == ST_RXDET)); // R2
  AST_NO_SKIP_CODES: assert property (@(posedge clk) disable iff (rst)
    (rx_status != ST_SKADD) && (rx_status != ST_SKREM)); // R4
  AST_QUIET_IS_DATA: assert property (@(posedge clk) disable iff (rst)
    (ev_flags == '0 && !phy_status_valid) |=> (rx_status == ST_DATA)); // R3
  AST_LAST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_status == ST_DATA) |-> $stable(last_err)); // R5
  AST_LAST_ERR_TRACK: assert property (@(posedge clk) disable iff (rst)
    (rx_status != ST_DATA) |-> (last_err == rx_status)); // R5
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    sym_ready); // R10
endmodule

// File: tb/rxst_resolver_test.sv
module rxst_resolver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ev_flags = '0;
  logic       phy_status_valid = 1'b0;
  logic [2:0] phy_status = '0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [7:0] sym_data = '0;
  logic       sym_is_k = 1'b0;
  logic [2:0] rx_status, last_err;
  logic       skip_cnt_valid, skip_added, skip_removed;
  logic [3:0] skip_cnt;

  always #4 clk = ~clk;  // 125 MHz

  rxst_resolver uut (.*);

  typedef struct {
    logic [2:0] st;
    logic [2:0] le;
    logic       skv;
    logic [3:0] cnt;
    logic       add;
    logic       rem;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model state
  logic [2:0] m_last = 3'b000;
  bit         m_inset = 0;
  int         m_cnt = 0;

  function automatic logic [2:0] ref_status(logic [4:0] f, logic pv, logic [2:0] pc);
    logic rxd, dec, ovf, unf, dsp;
    rxd = f[0] || (pv && pc == 3'b011);
    dec = f[1] || (pv && pc == 3'b100);
    ovf = f[2] || (pv && pc == 3'b101);
    unf = f[3] || (pv && pc == 3'b110);
    dsp = f[4] || (pv && pc == 3'b111);
    if (rxd)      return 3'b011;
    else if (dec) return 3'b100;
    else if (ovf) return 3'b101;
    else if (unf) return 3'b110;
    else if (dsp) return 3'b111;
    else          return 3'b000;
  endfunction

  task automatic drive(logic [4:0] f, logic pv, logic [2:0] pc,
                       logic sv, logic [7:0] d, logic k);
    exp_t e;
    @(negedge clk);
    ev_flags = f; phy_status_valid = pv; phy_status = pc;
    sym_valid = sv; sym_data = d; sym_is_k = k;
    e.st = ref_status(f, pv, pc);
    if (e.st != 3'b000) m_last = e.st;
    e.le = m_last;
    e.skv = 0; e.cnt = 0; e.add = 0; e.rem = 0;
    if (sv) begin
      if (!m_inset) begin
        if (k && d == 8'hBC) begin m_inset = 1; m_cnt = 0; end
      end else if (k && d == 8'h1C) begin
        m_cnt++;
      end else begin
        if (m_cnt > 0) begin
          e.skv = 1;
          e.cnt = (m_cnt > 15) ? 4'd15 : 4'(m_cnt);
          e.add = (m_cnt > 3);
          e.rem = (m_cnt < 3);
        end
        m_cnt = 0;
        m_inset = (k && d == 8'hBC);
      end
    end
    q.push_back(e);
  endtask

  task automatic sym(logic [7:0] d, logic k);
    drive(5'd0, 1'b0, 3'b000, 1'b1, d, k);
  endtask

  task automatic idle();
    drive(5'd0, 1'b0, 3'b000, 1'b0, 8'h1C, 1'b1);  // looks like SKP but not valid
  endtask

  task automatic skip_set(int n, bit gaps);
    sym(8'hBC, 1);
    for (int i = 0; i < n; i++) begin
      sym(8'h1C, 1);
      if (gaps) idle();
    end
    sym(8'h4A, 0);
    idle(); idle();
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    bit bad;
    wait (!rst);
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++; bad = 0;
        if (rx_status !== e.st) begin
          bad = 1; $display("FAIL R1/R2/R3/R4 rx_status actual=%b expected=%b", rx_status, e.st);
        end
        if (last_err !== e.le) begin
          bad = 1; $display("FAIL R5 last_err actual=%b expected=%b", last_err, e.le);
        end
        if (skip_cnt_valid !== e.skv) begin
          bad = 1; $display("FAIL R6/R8 skip_cnt_valid actual=%b expected=%b", skip_cnt_valid, e.skv);
        end
        if (e.skv && skip_cnt !== e.cnt) begin
          bad = 1; $display("FAIL R6/R9 skip_cnt actual=%0d expected=%0d", skip_cnt, e.cnt);
        end
        if (skip_added !== e.add || skip_removed !== e.rem) begin
          bad = 1; $display("FAIL R7 added/removed actual=%b%b expected=%b%b",
                            skip_added, skip_removed, e.add, e.rem);
        end
        if (sym_ready !== 1'b1) begin
          bad = 1; $display("FAIL R10 sym_ready actual=%b expected=1", sym_ready);
        end
        if (bad) n_bad++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;  // R1 reset state
    if (rx_status !== 3'b000 || last_err !== 3'b000 || skip_cnt_valid !== 1'b0 ||
        skip_added !== 1'b0 || skip_removed !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state actual=%b/%b/%b expected=000/000/0",
               rx_status, last_err, skip_cnt_valid);
    end
    @(negedge clk); rst = 0;

    // R2 R3 R4 R5: every flag combination crossed with every PHY code
    for (int f = 0; f < 32; f++) begin
      for (int c = 0; c < 8; c++) begin
        drive(5'(f), 1'b1, 3'(c), 1'b0, 8'h00, 1'b0);
      end
      drive(5'(f), 1'b0, 3'b011, 1'b0, 8'h00, 1'b0);  // R3 code ignored when not valid
      idle();                                           // R5 hold on data
    end
    // R3 skip add/remove codes alone read as data
    drive(5'd0, 1'b1, 3'b001, 1'b0, 8'h00, 1'b0);
    drive(5'd0, 1'b1, 3'b010, 1'b0, 8'h00, 1'b0);
    idle();

    // R6 R7 skip set lengths
    skip_set(3, 0);
    skip_set(2, 0);
    skip_set(4, 0);
    skip_set(1, 0);
    skip_set(3, 1);   // R6 idle gaps change nothing
    // R8 COM then data: no report
    sym(8'hBC, 1); sym(8'h4A, 0); idle(); idle();
    // R8 COM ends a set and starts a new one (back to back)
    sym(8'hBC, 1); sym(8'h1C, 1); sym(8'h1C, 1);
    sym(8'hBC, 1); sym(8'h1C, 1); sym(8'h1C, 1); sym(8'h1C, 1); sym(8'h1C, 1);
    sym(8'h4A, 0); idle(); idle();
    // SKP byte without control marker ends the set
    sym(8'hBC, 1); sym(8'h1C, 1); sym(8'h1C, 0); idle(); idle();
    // R9 saturation
    skip_set(17, 0);
    // events concurrent with a skip set
    sym(8'hBC, 1);
    drive(5'b10100, 1'b1, 3'b110, 1'b1, 8'h1C, 1'b1);
    drive(5'b00000, 1'b1, 3'b111, 1'b1, 8'h1C, 1'b1);
    drive(5'b00001, 1'b0, 3'b000, 1'b1, 8'h1C, 1'b1);
    drive(5'b00000, 1'b0, 3'b000, 1'b1, 8'h00, 1'b0);
    idle(); idle();

    repeat (4) @(posedge clk);
    #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule